// File: doc/BRIEF.md
# Core Halt State Controller

This block follows the power state of one processor core. The core runs in C0, the state it takes after reset. A halt-instruction strobe moves it into C1, a halted low-power state. From C1, any of five wake sources brings it back to C0: a system-management interrupt (SMI), an INIT request, the two local interrupt lines (NMI and INTR) and a bus interrupt message strobe. An active-low reset clears the controller at once from any state.

Entering SMI handling is a third internal mode, in which the core runs the handler. The controller records whether the core was halted when the SMI arrived. A return-from-SMI strobe carries a resume-halted flag. The core goes back to C1 only when the saved bit and the flag are both set, and otherwise it resumes running. Each exit from C1 latches a one-hot code that names the wake source. While the core is halted, the core-state output reports a deeper idle level taken from a separate request input, so that package-level logic can coordinate the cores.

Top module: `core_halt_ctrl`

## Requirements
- R1: An active-low `rst_n` clears the block asynchronously, overriding every other input: `halted`=0, `wake_cause`=0, `core_state`=0, saved-halt bit cleared, mode running.
- R2: In the running mode, a `halt_stb` pulse (with no `smi_req` in the same cycle) sets `halted` at the next clock edge.
- R3: While halted, any of `smi_req`, `init_req`, `nmi_req`, `intr_req` or `bus_msg_stb` clears `halted` at the next clock edge.
- R4: `wake_cause` is one-hot: bit 4 SMI, bit 3 INIT, bit 2 NMI, bit 1 INTR, bit 0 bus message. It is loaded only on an exit from the halted state and holds its value at all other times.
- R5: When several wake sources are active together, the highest-priority one is recorded, in the order SMI > INIT > NMI > INTR > bus message.
- R6: An SMI enters SMI mode, in which `halted`=0 and `core_state`=0. It sets the saved-halt bit if the core was halted, and clears it if the core was running. In the running mode an SMI takes priority over a simultaneous halt strobe.
- R7: In SMI mode, `rsm_stb` leaves the mode at the next edge. The core goes to halted if the saved-halt bit and `rsm_to_halt` are both 1, and to running otherwise.
- R8: `halt_stb` has no effect while halted or in SMI mode.
- R9: `core_state` is 0 when not halted. When halted it is 1 for `depth_req` of 0 or 1, equals `depth_req` for 2 to 4, and is 4 for values above 4.
- R10: In SMI mode, all wake inputs are ignored. In the running mode, INIT, NMI, INTR and bus messages have no effect on state or `wake_cause`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_stb | input | 1 | Halt-instruction strobe |
| smi_req | input | 1 | System-management interrupt |
| init_req | input | 1 | INIT request |
| nmi_req | input | 1 | Local non-maskable interrupt line |
| intr_req | input | 1 | Local maskable interrupt line |
| bus_msg_stb | input | 1 | Bus interrupt message strobe |
| rsm_stb | input | 1 | Return-from-SMI strobe |
| rsm_to_halt | input | 1 | Resume-halted flag qualifying `rsm_stb` |
| depth_req | input | 3 | Requested idle depth code, held while idle |
| halted | output | 1 | Core is in C1 |
| wake_cause | output | 5 | One-hot cause of the last C1 exit |
| core_state | output | 3 | Encoded core state for package coordination |

## Verification
A wrong mode register shows at the ports within one clock edge. `halted` and `core_state` are decoded directly from it, so a missed halt, a missed wake or a mishandled strobe appears on the next sample. A corrupted saved-halt bit stays hidden until the next return from SMI, where it shows as the wrong resume target. For this reason the bench sweeps every wake combination and follows each SMI case through to its resume. A wrong cause-latch enable shows as `wake_cause` changing on a later halt entry or on a strobe that is being ignored.

// File: rtl/chc_pkg.sv
package chc_pkg;
  localparam int WAKE_N = 5;
  localparam int IDX_SMI = 4;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_HALT = 2'd1,
    MODE_SMM  = 2'd2
  } chc_mode_e;
endpackage

// File: rtl/chc_wake_prio.sv
module chc_wake_prio #(
  parameter int N = 5
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);
  logic [N:0] above;
  assign above[N] = 1'b0;
  generate
    for (genvar i = N - 1; i >= 0; i--) begin : g_prio
      assign above[i] = above[i+1] | req[i];
      assign grant[i] = req[i] & ~above[i+1];
    end
  endgenerate
  assign any = above[0];
endmodule

// File: rtl/chc_core_fsm.sv
module chc_core_fsm
  import chc_pkg::*;
#(
  parameter int N = WAKE_N,
  parameter int SMI_BIT = IDX_SMI
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          halt_stb,
  input  logic          smi_req,
  input  logic          any_wake,
  input  logic [N-1:0]  grant,
  input  logic          rsm_stb,
  input  logic          rsm_to_halt,
  output chc_mode_e     mode_q,
  output logic          saved_q,
  output logic [N-1:0]  cause_q,
  output logic          ev_halt_enter,
  output logic          ev_wake,
  output logic          ev_resume
);
  chc_mode_e   mode_d;
  logic        saved_d;
  logic [N-1:0] cause_d;

  assign ev_halt_enter = (mode_q == MODE_RUN) && halt_stb && !smi_req;
  assign ev_wake       = (mode_q == MODE_HALT) && any_wake;
  assign ev_resume     = (mode_q == MODE_SMM) && rsm_stb;

  always_comb begin
    mode_d  = mode_q;
    saved_d = saved_q;
    cause_d = cause_q;
    unique case (mode_q)
      MODE_RUN: begin
        if (smi_req) begin
          mode_d  = MODE_SMM;
          saved_d = 1'b0;
        end else if (halt_stb) begin
          mode_d = MODE_HALT;
        end
      end
      MODE_HALT: begin
        if (any_wake) begin
          cause_d = grant;
          if (grant[SMI_BIT]) begin
            mode_d  = MODE_SMM;
            saved_d = 1'b1;
          end else begin
            mode_d = MODE_RUN;
          end
        end
      end
      MODE_SMM: begin
        if (rsm_stb) begin
          mode_d  = (saved_q && rsm_to_halt) ? MODE_HALT : MODE_RUN;
          saved_d = 1'b0;
        end
      end
      default: mode_d = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_RUN;
      saved_q <= 1'b0;
      cause_q <= '0;
    end else begin
      mode_q  <= mode_d;
      saved_q <= saved_d;
      cause_q <= cause_d;
    end
  end
endmodule

// File: rtl/chc_depth_map.sv
module chc_depth_map
  import chc_pkg::*;
#(
  parameter int CODE_W  = 3,
  parameter int DEEPEST = 4
) (
  input  chc_mode_e          mode,
  input  logic [CODE_W-1:0]  depth_req,
  output logic [CODE_W-1:0]  core_state
);
  localparam logic [CODE_W-1:0] CODE_HALT = CODE_W'(1);
  localparam logic [CODE_W-1:0] CODE_MAX  = CODE_W'(DEEPEST);

  function automatic logic [CODE_W-1:0] idle_code(input logic [CODE_W-1:0] req);
    if (req <= CODE_HALT)     return CODE_HALT;
    else if (req > CODE_MAX)  return CODE_MAX;
    else                      return req;
  endfunction

  assign core_state = (mode == MODE_HALT) ? idle_code(depth_req) : '0;
endmodule

// File: rtl/core_halt_ctrl.sv
module core_halt_ctrl
  import chc_pkg::*;
#(
  parameter int CODE_W  = 3,
  parameter int DEEPEST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt_stb,
  input  logic              smi_req,
  input  logic              init_req,
  input  logic              nmi_req,
  input  logic              intr_req,
  input  logic              bus_msg_stb,
  input  logic              rsm_stb,
  input  logic              rsm_to_halt,
  input  logic [CODE_W-1:0] depth_req,
  output logic              halted,
  output logic [WAKE_N-1:0] wake_cause,
  output logic [CODE_W-1:0] core_state
);
  logic [WAKE_N-1:0] wake_vec;
  logic [WAKE_N-1:0] wake_grant;
  logic              any_wake;
  chc_mode_e         mode_q;
  logic              saved_q;
  logic              ev_halt_enter;
  logic              ev_wake;
  logic              ev_resume;

  assign wake_vec = {smi_req, init_req, nmi_req, intr_req, bus_msg_stb};

  chc_wake_prio #(.N(WAKE_N)) u_prio (
    .req   (wake_vec),
    .grant (wake_grant),
    .any   (any_wake)
  );

  chc_core_fsm #(.N(WAKE_N), .SMI_BIT(IDX_SMI)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .halt_stb      (halt_stb),
    .smi_req       (smi_req),
    .any_wake      (any_wake),
    .grant         (wake_grant),
    .rsm_stb       (rsm_stb),
    .rsm_to_halt   (rsm_to_halt),
    .mode_q        (mode_q),
    .saved_q       (saved_q),
    .cause_q       (wake_cause),
    .ev_halt_enter (ev_halt_enter),
    .ev_wake       (ev_wake),
    .ev_resume     (ev_resume)
  );

  chc_depth_map #(.CODE_W(CODE_W), .DEEPEST(DEEPEST)) u_depth (
    .mode       (mode_q),
    .depth_req  (depth_req),
    .core_state (core_state)
  );

  assign halted = (mode_q == MODE_HALT);
endmodule

// File: rtl/chc_checker.sv
module chc_checker #(
  parameter int N = 5,
  parameter int CODE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              halt_stb,
  input logic              smi_req,
  input logic              rsm_stb,
  input logic              rsm_to_halt,
  input logic [1:0]        mode_q,
  input logic              saved_q,
  input logic              any_wake,
  input logic              ev_wake,
  input logic              halted,
  input logic [N-1:0]      wake_cause,
  input logic [CODE_W-1:0] core_state
);
  localparam logic [1:0] M_RUN = 2'd0;
  localparam logic [1:0] M_SMM = 2'd2;

  assert_halt_enter_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RUN && halt_stb && !smi_req) |=> halted);

  assert_wake_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && any_wake) |=> !halted);

  assert_cause_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wake_cause));

  assert_cause_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_wake |=> $stable(wake_cause));

  assert_resume_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SMM && rsm_stb && saved_q && rsm_to_halt) |=> halted);

  assert_resume_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SMM && rsm_stb && !(saved_q && rsm_to_halt)) |=> (mode_q == M_RUN));

  assert_halt_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !any_wake) |=> halted);

  assert_smm_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SMM && !rsm_stb) |=> (mode_q == M_SMM));

  assert_code_running_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !halted |-> (core_state == '0));
endmodule

bind core_halt_ctrl chc_checker #(.N(chc_pkg::WAKE_N), .CODE_W(CODE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .halt_stb    (halt_stb),
  .smi_req     (smi_req),
  .rsm_stb     (rsm_stb),
  .rsm_to_halt (rsm_to_halt),
  .mode_q      (mode_q),
  .saved_q     (saved_q),
  .any_wake    (any_wake),
  .ev_wake     (ev_wake),
  .halted      (halted),
  .wake_cause  (wake_cause),
  .core_state  (core_state)
);

// File: tb/core_halt_ctrl_test.sv
`timescale 1ns/1ps
module core_halt_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_stb = 0, smi_req = 0, init_req = 0, nmi_req = 0, intr_req = 0, bus_msg_stb = 0;
  logic rsm_stb = 0, rsm_to_halt = 0;
  logic [2:0] depth_req = 3'd0;
  logic halted;
  logic [4:0] wake_cause;
  logic [2:0] core_state;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  core_halt_ctrl uut (
    .clk(clk), .rst_n(rst_n), .halt_stb(halt_stb), .smi_req(smi_req),
    .init_req(init_req), .nmi_req(nmi_req), .intr_req(intr_req),
    .bus_msg_stb(bus_msg_stb), .rsm_stb(rsm_stb), .rsm_to_halt(rsm_to_halt),
    .depth_req(depth_req), .halted(halted), .wake_cause(wake_cause),
    .core_state(core_state)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic set_wake(input logic [4:0] w);
    {smi_req, init_req, nmi_req, intr_req, bus_msg_stb} = w;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic pulse_halt();
    halt_stb = 1'b1; tick(); halt_stb = 1'b0;
  endtask

  task automatic pulse_rsm(input logic flag);
    rsm_stb = 1'b1; rsm_to_halt = flag; tick(); rsm_stb = 1'b0; rsm_to_halt = 1'b0;
  endtask

  function automatic int prio_of(input logic [4:0] w);
    for (int i = 4; i >= 0; i--)
      if (w[i]) return 1 << i;
    return 0;
  endfunction

  function automatic int depth_exp(input int d);
    if (d < 2) return 1;
    if (d > 4) return 4;
    return d;
  endfunction

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int exp_c;
    tick();
    chk("R1 halted at reset", halted, 0);
    chk("R1 cause at reset", wake_cause, 0);
    chk("R1 code at reset", core_state, 0);
    rst_n = 1'b1;
    tick();

    pulse_halt();
    chk("R2 halted after strobe", halted, 1);
    chk("R9 code halted depth0", core_state, 1);

    for (int d = 0; d < 8; d++) begin
      depth_req = 3'(d);
      #0.5;
      chk("R9 depth map", core_state, depth_exp(d));
    end
    depth_req = 3'd0;

    pulse_halt();
    chk("R8 halt while halted", halted, 1);
    chk("R8 cause untouched", wake_cause, 0);

    for (int w = 1; w < 32; w++) begin
      do_reset();
      pulse_halt();
      set_wake(5'(w)); tick(); set_wake(5'd0);
      exp_c = prio_of(5'(w));
      chk("R3 wake exits halt", halted, 0);
      chk("R5 R4 priority cause", wake_cause, exp_c);
      chk("R9 code after wake", core_state, 0);
      if (w[4]) begin
        pulse_halt();
        chk("R8 halt in SMI mode", halted, 0);
        set_wake(5'b01111); tick(); set_wake(5'd0);
        chk("R10 wake ignored in SMI mode", halted, 0);
        chk("R10 cause held in SMI mode", wake_cause, exp_c);
        pulse_rsm(w[0]);
        chk("R7 resume target", halted, w[0]);
        chk("R6 code in resumed state", core_state, w[0] ? 1 : 0);
      end
      pulse_halt();
      chk("R4 cause held on halt entry", wake_cause, exp_c);
    end

    do_reset();
    set_wake(5'b10000); tick(); set_wake(5'd0);
    chk("R6 SMI from running", halted, 0);
    chk("R6 cause not loaded from running", wake_cause, 0);
    pulse_rsm(1'b1);
    chk("R7 saved bit clear resumes running", halted, 0);
    pulse_halt();
    chk("R7 core running after resume", halted, 1);

    do_reset();
    set_wake(5'b10000); halt_stb = 1'b1; tick(); set_wake(5'd0); halt_stb = 1'b0;
    chk("R6 SMI beats halt", halted, 0);
    pulse_rsm(1'b1);
    chk("R6 saved clear after SMI from run", halted, 0);

    do_reset();
    set_wake(5'b01111); tick(); set_wake(5'd0);
    chk("R10 wakes ignored while running", wake_cause, 0);
    pulse_halt();
    chk("R10 still running after wakes", halted, 1);

    depth_req = 3'd3;
    tick();
    halt_stb = 1'b1; set_wake(5'b11111);
    #1 rst_n = 1'b0;
    #0.5;
    chk("R1 async reset halted", halted, 0);
    chk("R1 async reset cause", wake_cause, 0);
    chk("R1 async reset code", core_state, 0);
    tick();
    halt_stb = 1'b0; set_wake(5'd0); depth_req = 3'd0;
    rst_n = 1'b1;
    tick();
    chk("R1 running after release", halted, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule